// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a low-power double-data-rate DRAM. It owns the command bus from reset until the memory is usable. It holds the clock enable high throughout. It drives only idle commands until a start pulse says the clock is stable. It then plays a fixed script with an idle window after every command:

- a long stabilization wait;
- a precharge of all banks;
- two auto-refresh commands;
- a standard mode-register load;
- an extended mode-register load.

When the last idle window has run out, it raises a ready flag. From then on it leaves the bus idle for the normal controller.

Every wait is a parameter given in clock cycles, and one shared down-counter times them all. A build-time option picks where the second auto-refresh goes. It can follow the first refresh directly, or it can come after the extended mode-register load and its gap, just before the ready flag. The two mode-register words are captured when the start pulse arrives. A reset at any point aborts the script and returns the block to its idle state, which models a power interruption. The control pins are plain level signals with no handshake.

Top module: `lpddr_pwrup_seq`

## Requirements
- R1: During reset, and after reset until a start pulse is seen, the block drives the idle (NOP) command. NOP is chip-select low with RAS, CAS and WE high (pins CS,RAS,CAS,WE = 0111). In that state the clock enable is high, bank and address are zero, and the ready flag is low.
- R2: A start pulse sampled in idle is followed by exactly max(T_INIT,1) NOP cycles before the first executable command.
- R3: The first executable command is PRECHARGE ALL: pins 0010, address bit 10 high, all other address bits zero, bank 00. It is followed by exactly max(T_RP,1) NOP cycles.
- R4: Exactly two AUTO REFRESH commands are issued, each with pins 0001, bank 00 and address zero. Each is followed by exactly max(T_RFC,1) NOP cycles.
- R5: The standard mode-register load drives pins 0000, bank 00, and the captured standard word on the address. It is followed by exactly max(T_MRD,1) NOP cycles.
- R6: The extended mode-register load drives pins 0000, bank 10 (binary), and the captured extended word on the address. It is followed by exactly max(T_MRD,1) NOP cycles.
- R7: With LATE_REFRESH=0 the order is precharge, refresh, refresh, standard load, extended load. With LATE_REFRESH=1 the order is precharge, refresh, standard load, extended load, refresh. No other command is issued.
- R8: The ready flag rises in the cycle right after the last NOP of the final gap. It then stays high, and the bus stays at NOP, until reset.
- R9: A start pulse has no effect while a sequence is running or after the ready flag is high.
- R10: The mode-register words are captured in the cycle the start pulse is accepted. Later changes on those inputs do not alter the loaded values.
- R11: A reset in the middle of a sequence brings the outputs back to the R1 state at once. A new start pulse then runs the full script from the beginning.
- R12: A timing parameter of zero is treated as one cycle, so every executable command is followed by at least one NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power interruption) |
| start_i | input | 1 | One-cycle pulse: clock is stable, begin the script |
| mr_std_i | input | ROW_W | Word for the standard mode register |
| mr_ext_i | input | ROW_W | Word for the extended mode register |
| cke_o | output | 1 | DRAM clock enable, held high |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank select |
| addr_o | output | ROW_W | Address lines |
| init_done_o | output | 1 | Sequence finished, bus free for normal traffic |

## Verification
The hardest situations to reach from the ports are a start pulse arriving while the long wait is still counting, and a reset that lands after some commands have already gone out. The stimulus reaches the first by pulsing start a second time a few cycles into the run, while the mode-word inputs are changed at the same moment. The expected gap counts then show that neither the timer nor the captured words moved. It reaches the second by resetting once the instance with the shorter stabilization wait has issued its precharge and the other is still waiting. Two instances run side by side, one for each refresh placement; the late-refresh one has zero-valued gaps to exercise the one-cycle floor.

// File: rtl/lpddr_init_pkg.sv
package lpddr_init_pkg;

  // Pin order: {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } dram_cmd_e;

  typedef enum logic [2:0] {
    STEP_PRE,
    STEP_REF_A,
    STEP_REF_B,
    STEP_MRS_STD,
    STEP_MRS_EXT,
    STEP_FINISH
  } init_step_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT,
    PH_CMD,
    PH_DONE
  } init_phase_e;

  // A wait never finishes early: zero is raised to one cycle.
  function automatic int unsigned at_least_one(int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lpddr_init_timer.sv
module lpddr_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/lpddr_init_steps.sv
module lpddr_init_steps
  import lpddr_init_pkg::*;
#(
  parameter bit               LATE_REFRESH = 1'b0,
  parameter int               CNT_W        = 16,
  parameter logic [CNT_W-1:0] RP_LOAD      = '0,
  parameter logic [CNT_W-1:0] RFC_LOAD     = '0,
  parameter logic [CNT_W-1:0] MRD_LOAD     = '0
) (
  input  init_step_e       step_i,
  output init_step_e       next_o,
  output logic [CNT_W-1:0] gap_load_o
);

  // Order of the script: the build option picks one of two variants.
  if (LATE_REFRESH) begin : g_late
    always_comb begin
      unique case (step_i)
        STEP_PRE:     next_o = STEP_REF_A;
        STEP_REF_A:   next_o = STEP_MRS_STD;
        STEP_MRS_STD: next_o = STEP_MRS_EXT;
        STEP_MRS_EXT: next_o = STEP_REF_B;
        default:      next_o = STEP_FINISH;
      endcase
    end
  end else begin : g_early
    always_comb begin
      unique case (step_i)
        STEP_PRE:     next_o = STEP_REF_A;
        STEP_REF_A:   next_o = STEP_REF_B;
        STEP_REF_B:   next_o = STEP_MRS_STD;
        STEP_MRS_STD: next_o = STEP_MRS_EXT;
        default:      next_o = STEP_FINISH;
      endcase
    end
  end

  // Idle window that follows the command of this step.
  always_comb begin
    unique case (step_i)
      STEP_PRE:                   gap_load_o = RP_LOAD;
      STEP_REF_A, STEP_REF_B:     gap_load_o = RFC_LOAD;
      STEP_MRS_STD, STEP_MRS_EXT: gap_load_o = MRD_LOAD;
      default:                    gap_load_o = '0;
    endcase
  end

endmodule

// File: rtl/lpddr_init_cmd.sv
module lpddr_init_cmd
  import lpddr_init_pkg::*;
#(
  parameter int ROW_W       = 13,
  parameter int BANK_W      = 2,
  parameter int PRE_ALL_BIT = 10,
  parameter int EXT_BANK    = 2
) (
  input  init_phase_e       phase_i,
  input  init_step_e        step_i,
  input  logic [ROW_W-1:0]  mr_std_i,
  input  logic [ROW_W-1:0]  mr_ext_i,
  output dram_cmd_e         cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o
);

  localparam logic [ROW_W-1:0]  PRE_ALL_ADDR = ROW_W'(1) << PRE_ALL_BIT;
  localparam logic [BANK_W-1:0] EXT_BA       = BANK_W'(EXT_BANK);

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (phase_i == PH_CMD) begin
      unique case (step_i)
        STEP_PRE: begin
          cmd_o  = CMD_PRE;
          addr_o = PRE_ALL_ADDR;
        end
        STEP_REF_A, STEP_REF_B: cmd_o = CMD_REF;
        STEP_MRS_STD: begin
          cmd_o  = CMD_LMR;
          addr_o = mr_std_i;
        end
        STEP_MRS_EXT: begin
          cmd_o  = CMD_LMR;
          ba_o   = EXT_BA;
          addr_o = mr_ext_i;
        end
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/lpddr_pwrup_seq.sv
module lpddr_pwrup_seq
  import lpddr_init_pkg::*;
#(
  parameter int ROW_W        = 13,
  parameter int BANK_W       = 2,
  parameter int T_INIT       = 50000,
  parameter int T_RP         = 5,
  parameter int T_RFC        = 20,
  parameter int T_MRD        = 2,
  parameter bit LATE_REFRESH = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  mr_std_i,
  input  logic [ROW_W-1:0]  mr_ext_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic              init_done_o
);

  localparam int unsigned INIT_CYC = at_least_one(T_INIT);
  localparam int unsigned RP_CYC   = at_least_one(T_RP);
  localparam int unsigned RFC_CYC  = at_least_one(T_RFC);
  localparam int unsigned MRD_CYC  = at_least_one(T_MRD);
  localparam int unsigned MAX_CYC  = max2(max2(INIT_CYC, RP_CYC), max2(RFC_CYC, MRD_CYC));
  localparam int          CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  localparam logic [CNT_W-1:0] INIT_LOAD = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0] RP_LOAD   = CNT_W'(RP_CYC - 1);
  localparam logic [CNT_W-1:0] RFC_LOAD  = CNT_W'(RFC_CYC - 1);
  localparam logic [CNT_W-1:0] MRD_LOAD  = CNT_W'(MRD_CYC - 1);

  init_phase_e      phase_q;
  init_step_e       step_q;
  init_step_e       step_next;
  logic [ROW_W-1:0] mr_std_q;
  logic [ROW_W-1:0] mr_ext_q;
  logic [CNT_W-1:0] gap_load;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             accept_start;
  dram_cmd_e        cmd;

  assign accept_start = (phase_q == PH_IDLE) && start_i;
  assign tmr_load     = accept_start || (phase_q == PH_CMD);
  assign tmr_val      = (phase_q == PH_IDLE) ? INIT_LOAD : gap_load;

  lpddr_init_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  lpddr_init_steps #(
    .LATE_REFRESH (LATE_REFRESH),
    .CNT_W        (CNT_W),
    .RP_LOAD      (RP_LOAD),
    .RFC_LOAD     (RFC_LOAD),
    .MRD_LOAD     (MRD_LOAD)
  ) u_steps (
    .step_i     (step_q),
    .next_o     (step_next),
    .gap_load_o (gap_load)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      step_q   <= STEP_PRE;
      mr_std_q <= '0;
      mr_ext_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q  <= PH_WAIT;
            step_q   <= STEP_PRE;
            mr_std_q <= mr_std_i;
            mr_ext_q <= mr_ext_i;
          end
        end
        PH_WAIT: begin
          if (tmr_expired) begin
            phase_q <= (step_q == STEP_FINISH) ? PH_DONE : PH_CMD;
          end
        end
        PH_CMD: begin
          phase_q <= PH_WAIT;
          step_q  <= step_next;
        end
        default: phase_q <= PH_DONE;
      endcase
    end
  end

  lpddr_init_cmd #(
    .ROW_W       (ROW_W),
    .BANK_W      (BANK_W),
    .PRE_ALL_BIT (10),
    .EXT_BANK    (2)
  ) u_cmd (
    .phase_i  (phase_q),
    .step_i   (step_q),
    .mr_std_i (mr_std_q),
    .mr_ext_i (mr_ext_q),
    .cmd_o    (cmd),
    .ba_o     (ba_o),
    .addr_o   (addr_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign cke_o       = 1'b1;
  assign init_done_o = (phase_q == PH_DONE);

endmodule

// File: rtl/lpddr_pwrup_seq_chk.sv
module lpddr_pwrup_seq_chk #(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [BANK_W-1:0] ba_o,
  input logic [ROW_W-1:0]  addr_o,
  input logic              init_done_o
);

  logic [3:0] pins;
  logic       is_nop;
  logic       started_q;
  logic       any_cmd_q;
  logic [1:0] ref_cnt_q;

  assign pins   = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign is_nop = (pins == 4'b0111);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      any_cmd_q <= 1'b0;
      ref_cnt_q <= '0;
    end else begin
      if (start_i) started_q <= 1'b1;
      if (!is_nop) any_cmd_q <= 1'b1;
      if (pins == 4'b0001 && ref_cnt_q != 2'd3) ref_cnt_q <= ref_cnt_q + 2'd1;
    end
  end

  assert_idle_nop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> (is_nop && !init_done_o));

  assert_pre_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0010) |-> (addr_o[10] && ba_o == '0));

  assert_two_refresh_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (ref_cnt_q == 2'd2));

  // R5 and R6: mode loads address bank 00 or 10 only
  assert_lmr_bank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0000) |-> (ba_o == BANK_W'(0) || ba_o == BANK_W'(2)));

  assert_first_is_pre_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_nop && !any_cmd_q) |-> (pins == 4'b0010));

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  assert_done_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> is_nop);

  assert_gap_floor_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_nop |=> is_nop);

endmodule

bind lpddr_pwrup_seq lpddr_pwrup_seq_chk #(
  .ROW_W  (ROW_W),
  .BANK_W (BANK_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .cs_n_o      (cs_n_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .init_done_o (init_done_o)
);

// File: tb/lpddr_pwrup_seq_tb.sv
`timescale 1ns/1ps
module lpddr_pwrup_seq_tb;

  localparam int ROW_W = 13;
  // instance 0: early refresh; instance 1: late refresh with zero gaps
  localparam int TI0 = 40, TRP0 = 3, TRFC0 = 7, TMRD0 = 2;
  localparam int TI1 = 25, TRP1 = 0, TRFC1 = 5, TMRD1 = 0;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] DONE_MARK = 4'b1111;

  typedef struct {
    logic [3:0]       cmd;
    logic [1:0]       ba;
    logic [ROW_W-1:0] addr;
    int               gap;
    string            req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [ROW_W-1:0] mr_std = '0;
  logic [ROW_W-1:0] mr_ext = '0;

  logic [1:0]            cke_w, cs_w, ras_w, cas_w, we_w, done_w;
  logic [1:0][1:0]       ba_w;
  logic [1:0][ROW_W-1:0] addr_w;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  exp_t expq [2][$];
  int   nop_cnt [2];
  bit   run [2];
  bit   done_seen [2];

  always #2 clk = ~clk;

  lpddr_pwrup_seq #(
    .ROW_W(ROW_W), .BANK_W(2), .T_INIT(TI0), .T_RP(TRP0), .T_RFC(TRFC0),
    .T_MRD(TMRD0), .LATE_REFRESH(1'b0)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mr_std_i(mr_std), .mr_ext_i(mr_ext),
    .cke_o(cke_w[0]), .cs_n_o(cs_w[0]), .ras_n_o(ras_w[0]), .cas_n_o(cas_w[0]),
    .we_n_o(we_w[0]), .ba_o(ba_w[0]), .addr_o(addr_w[0]), .init_done_o(done_w[0])
  );

  lpddr_pwrup_seq #(
    .ROW_W(ROW_W), .BANK_W(2), .T_INIT(TI1), .T_RP(TRP1), .T_RFC(TRFC1),
    .T_MRD(TMRD1), .LATE_REFRESH(1'b1)
  ) u_dut_late (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mr_std_i(mr_std), .mr_ext_i(mr_ext),
    .cke_o(cke_w[1]), .cs_n_o(cs_w[1]), .ras_n_o(ras_w[1]), .cas_n_o(cas_w[1]),
    .we_n_o(we_w[1]), .ba_o(ba_w[1]), .addr_o(addr_w[1]), .init_done_o(done_w[1])
  );

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int floor1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic exp_t mk(input logic [3:0] c, input logic [1:0] b,
                              input logic [ROW_W-1:0] a, input int g, input string r);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.gap = g; e.req = r;
    return e;
  endfunction

  // Driver side: expected script for one instance, from the requirements
  task automatic push_run(input int i, input bit late, input int ti, input int trp,
                          input int trfc, input int tmrd);
    expq[i].push_back(mk(4'b0010, 2'd0, 13'h0400, floor1(ti), "R2 R3 pre-all"));
    expq[i].push_back(mk(4'b0001, 2'd0, '0, floor1(trp), "R4 R12 refresh1"));
    if (!late) begin
      expq[i].push_back(mk(4'b0001, 2'd0, '0, floor1(trfc), "R4 R7 refresh2"));
      expq[i].push_back(mk(4'b0000, 2'd0, mr_std, floor1(trfc), "R5 R10 std-load"));
      expq[i].push_back(mk(4'b0000, 2'd2, mr_ext, floor1(tmrd), "R6 R10 ext-load"));
      expq[i].push_back(mk(DONE_MARK, 2'd0, '0, floor1(tmrd), "R8 ready"));
    end else begin
      expq[i].push_back(mk(4'b0000, 2'd0, mr_std, floor1(trfc), "R5 R7 std-load"));
      expq[i].push_back(mk(4'b0000, 2'd2, mr_ext, floor1(tmrd), "R6 R12 ext-load"));
      expq[i].push_back(mk(4'b0001, 2'd0, '0, floor1(tmrd), "R4 R7 R12 late-refresh"));
      expq[i].push_back(mk(DONE_MARK, 2'd0, '0, floor1(trfc), "R8 ready"));
    end
  endtask

  task automatic push_both();
    push_run(0, 1'b0, TI0, TRP0, TRFC0, TMRD0);
    push_run(1, 1'b1, TI1, TRP1, TRFC1, TMRD1);
  endtask

  // Monitor: samples on the falling edge, pops and compares
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      logic [3:0] c;
      c = {cs_w[i], ras_w[i], cas_w[i], we_w[i]};
      if (!rst_n) begin
        run[i] = 1'b0; done_seen[i] = 1'b0; nop_cnt[i] = 0;
      end else if (!run[i]) begin
        if (c != NOP || done_w[i])
          check(1'b0, $sformatf("R1 R2 inst%0d activity before start: cmd=%b done=%b expected cmd=%b done=0",
                                i, c, done_w[i], NOP));
        if (start) begin run[i] = 1'b1; nop_cnt[i] = 0; end
      end else if (done_seen[i]) begin
        if (c != NOP || !done_w[i] || cke_w[i] !== 1'b1)
          check(1'b0, $sformatf("R8 R9 inst%0d after ready: cmd=%b done=%b cke=%b expected cmd=%b done=1 cke=1",
                                i, c, done_w[i], cke_w[i], NOP));
      end else if (c != NOP || done_w[i]) begin
        logic [3:0] got;
        got = (c == NOP) ? DONE_MARK : c;
        if (expq[i].size() == 0) begin
          check(1'b0, $sformatf("R7 inst%0d unexpected cmd=%b expected none", i, got));
        end else begin
          exp_t e;
          e = expq[i].pop_front();
          check(got == e.cmd && ba_w[i] == e.ba && addr_w[i] == e.addr &&
                nop_cnt[i] == e.gap && cke_w[i] === 1'b1,
                $sformatf("%s inst%0d: cmd=%b ba=%0d addr=%h gap=%0d cke=%b expected cmd=%b ba=%0d addr=%h gap=%0d cke=1",
                          e.req, i, got, ba_w[i], addr_w[i], nop_cnt[i], cke_w[i],
                          e.cmd, e.ba, e.addr, e.gap));
        end
        nop_cnt[i] = 0;
        if (done_w[i]) done_seen[i] = 1'b1;
      end else begin
        nop_cnt[i]++;
      end
    end
  end

  task automatic check_idle(input string tag);
    @(negedge clk);
    #0.5;
    for (int i = 0; i < 2; i++) begin
      check({cs_w[i], ras_w[i], cas_w[i], we_w[i]} == NOP && cke_w[i] === 1'b1 &&
            done_w[i] == 1'b0 && ba_w[i] == '0 && addr_w[i] == '0,
            $sformatf("%s inst%0d idle: cmd=%b cke=%b done=%b ba=%0d addr=%h expected cmd=%b cke=1 done=0 ba=0 addr=0",
                      tag, i, {cs_w[i], ras_w[i], cas_w[i], we_w[i]}, cke_w[i],
                      done_w[i], ba_w[i], addr_w[i], NOP));
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    while (done_w != 2'b11 && n < 3000) begin
      @(posedge clk);
      n++;
    end
    repeat (2) @(posedge clk);
    check(done_w == 2'b11, $sformatf("R8 %s ready flags: got=%b expected=11", tag, done_w));
    for (int i = 0; i < 2; i++)
      check(expq[i].size() == 0,
            $sformatf("R7 %s inst%0d leftover items: got=%0d expected=0", tag, i, expq[i].size()));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mr_std = 13'h0031;
    mr_ext = 13'h0020;
    repeat (4) @(posedge clk);
    check_idle("R1 in-reset");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (10) @(posedge clk);
    check_idle("R1 post-reset");

    // Run 1: second start and new mode words mid-wait must be ignored
    push_both();
    pulse_start();
    repeat (3) @(posedge clk);
    #1 mr_std = 13'h1FFF; mr_ext = 13'h1FFF;
    pulse_start();                       // R9 while running
    wait_ready("run1");
    pulse_start();                       // R9 after ready
    repeat (20) @(posedge clk);
    check(done_w == 2'b11, $sformatf("R9 ready after late start: got=%b expected=11", done_w));

    // Run 2: reset lands mid-script (R11)
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mr_std = 13'h0A5A;
    mr_ext = 13'h0007;
    push_both();
    pulse_start();
    repeat (32) @(posedge clk);
    #1 rst_n = 1'b0;
    expq[0].delete();
    expq[1].delete();
    check_idle("R11 mid-run reset");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    check_idle("R11 after reset");

    // Run 3: full script again after the interruption
    mr_std = 13'h1234;
    mr_ext = 13'h0C03;
    push_both();
    pulse_start();
    wait_ready("R11 rerun");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule